// File: doc/BRIEF.md
# Programmable Clique-Energy Logic Evaluator

This block computes a pair of logic functions by energy minimisation rather than by fixed gates. Two observed input bits and one hidden output bit form a three-node clique. A third-order polynomial with programmable signed coefficients gives an energy to each of the eight node configurations. For each input pair, the block evaluates the energy with the hidden bit at 0 and at 1. It then registers the cheaper choice as the output.

There are two independent cliques, each with its own coefficient word. The sum clique is intended to behave as XOR and the carry clique as AND. Together they form a half adder whose logic comes entirely from the coefficient values.

A check sweep steps through all eight configurations of one clique, one per cycle. It reports whether every valid configuration is strictly cheaper than every invalid one. It also reports the closest valid/invalid pair, so that coefficient drift can be caught before it corrupts results.

Top module: `clq_logic_eval`

## Requirements
- R1: Each coefficient word packs eight signed 8-bit fields: A in bits 7:0, B in 15:8, C in 23:16, D in 31:24, E in 39:32, F in 47:40, G in 55:48 and the offset O in 63:56. For node bits x0=in_a, x1=in_b and x2=candidate output, the energy is O + A·x0 + B·x1 + C·x2 − 2D·x0·x1 − 2E·x0·x2 − 2F·x1·x2 + 4G·x0·x1·x2. Each output is the candidate with the lower energy.
- R2: Outputs are registered. On the rising edge where in_valid is high, the block updates sum_out, sum_tie, carry_out and carry_tie, and raises out_valid for exactly that one following cycle. Otherwise out_valid is low and the results hold their values.
- R3: When both candidate energies are equal, the output is 0 and the matching tie flag is 1. Otherwise the tie flag is 0.
- R4: The sum output depends only on sum_coef and the carry output depends only on carry_coef.
- R5: The nominal sum coefficients are A through G all 1 with O=−1, and they give XOR. The nominal carry coefficients are A=0, B=0, C=2, D=−1, E=0, F=0, G=−1 with O=−2, and they give AND.
- R6: A chk_start seen on an edge while idle begins a sweep and sets chk_busy. Eight edges later, chk_done pulses high for one cycle and chk_busy falls.
- R7: chk_sel=0 sweeps the sum clique, whose valid states satisfy x2 = x0 XOR x1. chk_sel=1 sweeps the carry clique, whose valid states satisfy x2 = x0 AND x1. chk_pass is 1 exactly when every valid energy is strictly below every invalid energy.
- R8: At chk_done, chk_worst_valid gives the state index {x0,x1,x2} of the highest-energy valid state, and chk_worst_invalid gives the index of the lowest-energy invalid state. On equal energies the lower index wins.
- R9: The block ignores chk_start and changes to chk_sel while a sweep is running. Such a change neither restarts the sweep nor alters its result.
- R10: The offset field shifts both candidate energies equally, so it never changes an output or tie flag.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair valid for evaluation |
| in_a | input | 1 | Observed node x0 |
| in_b | input | 1 | Observed node x1 |
| sum_coef | input | 64 | Sum clique coefficient word |
| carry_coef | input | 64 | Carry clique coefficient word |
| chk_start | input | 1 | Begin an ordering sweep |
| chk_sel | input | 1 | Sweep target: 0 sum, 1 carry |
| out_valid | output | 1 | One-cycle result strobe |
| sum_out | output | 1 | Minimum-energy sum bit |
| sum_tie | output | 1 | Sum candidates had equal energy |
| carry_out | output | 1 | Minimum-energy carry bit |
| carry_tie | output | 1 | Carry candidates had equal energy |
| chk_busy | output | 1 | Sweep in progress |
| chk_done | output | 1 | Sweep result strobe |
| chk_pass | output | 1 | Valid states all strictly cheaper |
| chk_worst_valid | output | 3 | Highest-energy valid state index |
| chk_worst_invalid | output | 3 | Lowest-energy invalid state index |

## Verification
Evaluation results are due one edge after the input is presented. The bench drives each input on a falling edge, releases in_valid on the next falling edge, and samples the outputs at that same point. A sweep result is due exactly eight edges after the edge that accepts chk_start. The bench counts falling edges from the accepting edge and requires chk_done to appear at count eight, then confirms one falling edge later that the pulse has ended and that no second sweep started. Expected outputs, tie flags, pass results and worst-pair indices all come from an arithmetic energy model inside the bench.

// File: rtl/clq_pkg.sv
package clq_pkg;
  localparam int NCOEF  = 8;
  localparam int NSTATE = 8;

  typedef enum logic {FN_SUM = 1'b0, FN_CARRY = 1'b1} clq_fn_e;

  // state index is {x0, x1, x2}; x2 is the hidden output node
  function automatic logic state_ok(clq_fn_e fn, logic [2:0] st);
    if (fn == FN_SUM) return st[0] == (st[2] ^ st[1]);
    return st[0] == (st[2] & st[1]);
  endfunction
endpackage

// File: rtl/clq_energy.sv
module clq_energy #(
  parameter int CW = 8,
  parameter int EW = 14
) (
  input  logic [clq_pkg::NCOEF*CW-1:0] coef,
  input  logic [2:0]                   st,
  output logic signed [EW-1:0]         energy
);
  logic signed [EW-1:0] cx [clq_pkg::NCOEF];

  generate
    for (genvar k = 0; k < clq_pkg::NCOEF; k++) begin : g_ext
      assign cx[k] = {{(EW-CW){coef[k*CW+CW-1]}}, coef[k*CW +: CW]};
    end
  endgenerate

  always_comb begin
    energy = cx[7];
    if (st[2]) energy = energy + cx[0];
    if (st[1]) energy = energy + cx[1];
    if (st[0]) energy = energy + cx[2];
    if (st[2] && st[1]) energy = energy - (cx[3] <<< 1);
    if (st[2] && st[0]) energy = energy - (cx[4] <<< 1);
    if (st[1] && st[0]) energy = energy - (cx[5] <<< 1);
    if (&st)            energy = energy + (cx[6] <<< 2);
  end
endmodule

// File: rtl/clq_lane.sv
module clq_lane #(
  parameter int CW = 8,
  parameter int EW = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         x0,
  input  logic                         x1,
  input  logic [clq_pkg::NCOEF*CW-1:0] coef,
  output logic                         out_bit,
  output logic                         out_tie
);
  logic signed [EW-1:0] e_lo, e_hi;

  clq_energy #(.CW(CW), .EW(EW)) u_e0 (.coef(coef), .st({x0, x1, 1'b0}), .energy(e_lo));
  clq_energy #(.CW(CW), .EW(EW)) u_e1 (.coef(coef), .st({x0, x1, 1'b1}), .energy(e_hi));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bit <= 1'b0;
      out_tie <= 1'b0;
    end else if (in_valid) begin
      out_bit <= (e_hi < e_lo);
      out_tie <= (e_hi == e_lo);
    end
  end

  AST_TIE_LOW: assert property (@(posedge clk) disable iff (rst) out_tie |-> !out_bit); // R3
endmodule

// File: rtl/clq_sweep.sv
module clq_sweep #(
  parameter int CW = 8,
  parameter int EW = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         sel,
  input  logic [clq_pkg::NCOEF*CW-1:0] sum_coef,
  input  logic [clq_pkg::NCOEF*CW-1:0] carry_coef,
  output logic                         busy,
  output logic                         done,
  output logic                         pass,
  output logic [2:0]                   worst_valid,
  output logic [2:0]                   worst_invalid
);
  import clq_pkg::*;

  localparam logic [2:0] LAST = 3'(NSTATE - 1);
  localparam logic signed [EW-1:0] E_HI = {1'b0, {(EW-1){1'b1}}};
  localparam logic signed [EW-1:0] E_LO = {1'b1, {(EW-1){1'b0}}};

  clq_fn_e              fn;
  logic [2:0]           idx;
  logic signed [EW-1:0] max_v, min_i, nxt_max_v, nxt_min_i, e_cur;
  logic [2:0]           max_v_idx, min_i_idx, nxt_max_v_idx, nxt_min_i_idx;
  logic [NCOEF*CW-1:0]  coef_cur;
  logic                 cur_ok;

  assign coef_cur = (fn == FN_CARRY) ? carry_coef : sum_coef;
  assign cur_ok   = state_ok(fn, idx);

  clq_energy #(.CW(CW), .EW(EW)) u_e (.coef(coef_cur), .st(idx), .energy(e_cur));

  always_comb begin
    nxt_max_v     = max_v;
    nxt_max_v_idx = max_v_idx;
    nxt_min_i     = min_i;
    nxt_min_i_idx = min_i_idx;
    if (cur_ok && (e_cur > max_v)) begin
      nxt_max_v     = e_cur;
      nxt_max_v_idx = idx;
    end
    if (!cur_ok && (e_cur < min_i)) begin
      nxt_min_i     = e_cur;
      nxt_min_i_idx = idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      done          <= 1'b0;
      pass          <= 1'b0;
      worst_valid   <= '0;
      worst_invalid <= '0;
      fn            <= FN_SUM;
      idx           <= '0;
      max_v         <= E_LO;
      min_i         <= E_HI;
      max_v_idx     <= '0;
      min_i_idx     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          fn        <= clq_fn_e'(sel);
          idx       <= '0;
          max_v     <= E_LO;
          min_i     <= E_HI;
          max_v_idx <= '0;
          min_i_idx <= '0;
        end
      end else begin
        max_v     <= nxt_max_v;
        min_i     <= nxt_min_i;
        max_v_idx <= nxt_max_v_idx;
        min_i_idx <= nxt_min_i_idx;
        idx       <= idx + 3'd1;
        if (idx == LAST) begin
          busy          <= 1'b0;
          done          <= 1'b1;
          pass          <= (nxt_max_v < nxt_min_i);
          worst_valid   <= nxt_max_v_idx;
          worst_invalid <= nxt_min_i_idx;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy)); // R6
  AST_WORST_CLASS: assert property (@(posedge clk) disable iff (rst)
    done |-> (state_ok(fn, worst_valid) && !state_ok(fn, worst_invalid))); // R8
endmodule

// File: rtl/clq_logic_eval.sv
module clq_logic_eval #(
  parameter int CW = 8,
  parameter int EW = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_a,
  input  logic                         in_b,
  input  logic [clq_pkg::NCOEF*CW-1:0] sum_coef,
  input  logic [clq_pkg::NCOEF*CW-1:0] carry_coef,
  input  logic                         chk_start,
  input  logic                         chk_sel,
  output logic                         out_valid,
  output logic                         sum_out,
  output logic                         sum_tie,
  output logic                         carry_out,
  output logic                         carry_tie,
  output logic                         chk_busy,
  output logic                         chk_done,
  output logic                         chk_pass,
  output logic [2:0]                   chk_worst_valid,
  output logic [2:0]                   chk_worst_invalid
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  clq_lane #(.CW(CW), .EW(EW)) u_sum (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x0(in_a), .x1(in_b),
    .coef(sum_coef), .out_bit(sum_out), .out_tie(sum_tie));

  clq_lane #(.CW(CW), .EW(EW)) u_carry (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x0(in_a), .x1(in_b),
    .coef(carry_coef), .out_bit(carry_out), .out_tie(carry_tie));

  clq_sweep #(.CW(CW), .EW(EW)) u_sweep (
    .clk(clk), .rst(rst), .start(chk_start), .sel(chk_sel),
    .sum_coef(sum_coef), .carry_coef(carry_coef),
    .busy(chk_busy), .done(chk_done), .pass(chk_pass),
    .worst_valid(chk_worst_valid), .worst_invalid(chk_worst_invalid));

  AST_OUT_STROBE: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sum_out) && $stable(carry_out))); // R2
endmodule

// File: tb/clq_logic_eval_tb.sv
`timescale 1ns/1ps
module clq_logic_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_a = 1'b0, in_b = 1'b0;
  logic [63:0] sum_coef = '0, carry_coef = '0;
  logic        chk_start = 1'b0, chk_sel = 1'b0;
  logic        out_valid, sum_out, sum_tie, carry_out, carry_tie;
  logic        chk_busy, chk_done, chk_pass;
  logic [2:0]  chk_worst_valid, chk_worst_invalid;

  int tests = 0, fails = 0;
  int sc[8];
  int cc[8];

  always #4 clk = ~clk;

  clq_logic_eval dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .sum_coef(sum_coef), .carry_coef(carry_coef), .chk_start(chk_start), .chk_sel(chk_sel),
    .out_valid(out_valid), .sum_out(sum_out), .sum_tie(sum_tie),
    .carry_out(carry_out), .carry_tie(carry_tie), .chk_busy(chk_busy),
    .chk_done(chk_done), .chk_pass(chk_pass),
    .chk_worst_valid(chk_worst_valid), .chk_worst_invalid(chk_worst_invalid));

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int energy(int c[8], int st);
    int x0 = (st >> 2) & 1;
    int x1 = (st >> 1) & 1;
    int x2 = st & 1;
    return c[7] + c[0]*x0 + c[1]*x1 + c[2]*x2 - 2*c[3]*x0*x1 - 2*c[4]*x0*x2
           - 2*c[5]*x1*x2 + 4*c[6]*x0*x1*x2;
  endfunction

  function automatic bit valid_st(int fn, int st);
    int x0 = (st >> 2) & 1;
    int x1 = (st >> 1) & 1;
    if (fn == 0) return (st & 1) == (x0 ^ x1);
    return (st & 1) == (x0 & x1);
  endfunction

  function automatic logic [63:0] pack(int c[8]);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'(c[k]);
    return v;
  endfunction

  task automatic load();
    sum_coef   = pack(sc);
    carry_coef = pack(cc);
  endtask

  task automatic model_chk(int c[8], int fn, output bit ok, output int wv, output int wi);
    int mv = -100000;
    int mi = 100000;
    wv = 0; wi = 0;
    for (int s = 0; s < 8; s++) begin
      int e = energy(c, s);
      if (valid_st(fn, s) && e > mv) begin mv = e; wv = s; end
      if (!valid_st(fn, s) && e < mi) begin mi = e; wi = s; end
    end
    ok = (mv < mi);
  endtask

  // evaluates all four input pairs; returns whether outputs equal XOR / AND
  task automatic eval_all(string tag, output bit is_xor, output bit is_and);
    is_xor = 1; is_and = 1;
    for (int p = 0; p < 4; p++) begin
      int a = p >> 1;
      int b = p & 1;
      int s0 = energy(sc, a*4 + b*2);
      int s1 = energy(sc, a*4 + b*2 + 1);
      int c0 = energy(cc, a*4 + b*2);
      int c1 = energy(cc, a*4 + b*2 + 1);
      @(negedge clk);
      in_valid = 1; in_a = a[0]; in_b = b[0];
      @(negedge clk);
      in_valid = 0;
      check(out_valid == 1, {"R2 strobe ", tag}, out_valid, 1);
      check(sum_out == (s1 < s0), {"R1 sum ", tag}, sum_out, s1 < s0);
      check(sum_tie == (s1 == s0), {"R3 sum tie ", tag}, sum_tie, s1 == s0);
      check(carry_out == (c1 < c0), {"R1 R4 carry ", tag}, carry_out, c1 < c0);
      check(carry_tie == (c1 == c0), {"R3 carry tie ", tag}, carry_tie, c1 == c0);
      if (sum_out != (a ^ b)) is_xor = 0;
      if (carry_out != (a & b)) is_and = 0;
    end
    @(negedge clk);
    check(out_valid == 0, {"R2 strobe low ", tag}, out_valid, 0);
  endtask

  task automatic run_chk(int fn, bit poke, string tag);
    bit ok; int wv, wi; int n = 0; bit seen = 0;
    if (fn == 0) model_chk(sc, 0, ok, wv, wi); else model_chk(cc, 1, ok, wv, wi);
    @(negedge clk);
    chk_sel = fn[0]; chk_start = 1;
    @(negedge clk);
    chk_start = 0;
    check(chk_busy == 1, {"R6 busy ", tag}, chk_busy, 1);
    while (!seen && n < 20) begin
      if (poke && n == 2) begin chk_start = 1; chk_sel = ~fn[0]; end
      @(negedge clk);
      chk_start = 0;
      n++;
      if (chk_done) seen = 1;
    end
    check(n == 8, {"R6 done timing ", tag}, n, 8);
    check(chk_pass == ok, {"R7 pass ", tag}, chk_pass, ok);
    check(chk_worst_valid == wv, {"R8 worst valid ", tag}, chk_worst_valid, wv);
    check(chk_worst_invalid == wi, {"R8 worst invalid ", tag}, chk_worst_invalid, wi);
    @(negedge clk);
    check(chk_done == 0 && chk_busy == 0, {"R9 R6 idle after ", tag}, chk_busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit xr, an, ok; int wv, wi;
    sc = '{1, 1, 1, 1, 1, 1, 1, -1};
    cc = '{0, 0, 2, -1, 0, 0, -1, -2};
    load();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check({out_valid, sum_out, sum_tie, carry_out, carry_tie, chk_busy, chk_done, chk_pass,
           chk_worst_valid, chk_worst_invalid} == 0, "R11 reset state", out_valid, 0);

    eval_all("nominal", xr, an);
    check(xr, "R5 nominal XOR", xr, 1);
    check(an, "R5 nominal AND", an, 1);
    run_chk(0, 0, "nominal sum");
    run_chk(1, 0, "nominal carry");

    sc[7] = 50; cc[7] = 30; load();
    eval_all("offset", xr, an);
    check(xr && an, "R10 offset no effect", xr && an, 1);

    sc = '{0, 0, 0, 0, 0, 0, 0, 0}; cc[7] = -2; load();
    eval_all("tie", xr, an);
    check(an, "R4 carry unaffected by sum coef", an, 1);

    sc = '{1, 1, 1, 1, 1, 0, 1, -1}; load();
    eval_all("broken", xr, an);
    run_chk(0, 1, "broken sum poked");
    run_chk(1, 1, "carry poked");

    for (int r = 0; r < 24; r++) begin
      int ks[8] = '{12, 12, 12, 12, 12, 12, 12, -12};
      int kc[8] = '{0, 0, 12, -6, 0, 0, -6, -12};
      for (int k = 0; k < 8; k++) begin
        sc[k] = ks[k] + int'($urandom_range(0, 8)) - 4;
        cc[k] = (kc[k] == 0) ? 0 : kc[k] + int'($urandom_range(0, 4)) - 2;
      end
      load();
      eval_all("random", xr, an);
      model_chk(sc, 0, ok, wv, wi);
      if (ok) check(xr, "R7 ordered sum gives XOR", xr, 1);
      model_chk(cc, 1, ok, wv, wi);
      if (ok) check(an, "R7 ordered carry gives AND", an, 1);
      run_chk(0, 0, "random sum");
      run_chk(1, 0, "random carry");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule